// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block sits at the front of a floating-point unit and turns one 32-bit instruction word into a registered decode bundle. It sorts each word into a floating-point load or store, an arithmetic, fused multiply-add or select operation, a compare, a register move, or an operation on the floating-point status register. It also returns the operand register indices and immediate fields, and a mask showing which source registers the operation reads.

For memory operations the block forms the effective address from two general-register values supplied by the register file. One is the register named by bits [20:16] and the other is the register named by bits [15:11]. The block rejects encodings that are not defined. It reports when a memory operation must write its address back to the base register, and when the top four status bits must be copied into condition-register field 1 after execution. Execution and memory access belong to later stages.

Top module: `fp_insn_decoder`

## Requirements
- R1: All outputs are registered. `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. While `in_valid` is low every other output holds its value. Reset clears every output to zero.
- R2: Primary opcode `insn[31:26]` 48..55 decodes as an immediate-displacement memory operation (`is_mem`=1). The pairs 48/49, 50/51, 52/53 and 54/55 give OP_LOAD_S, OP_LOAD_D, OP_STORE_S and OP_STORE_D. Within each pair the odd code is the base-update form.
- R3: Primary opcode 31 decodes the 10-bit field `insn[10:1]`. The indexed forms are 535/567 for load single, 599/631 for load double, 663/695 for store single and 727/759 for store double, with the second value of each pair being the update form. Value 983 is store-as-integer-word (OP_STORE_IW). Any other value, and any primary opcode other than 31, 48..55, 59 and 63, gives `illegal`=1 and `op`=0 (OP_ILLEGAL) with `single_prec`, `src_mask`, `is_mem`, `base_wb`, `cr1_copy` and `ea` all zero.
- R4: Primary opcode 59 decodes `insn[5:1]` with `single_prec`=1. The codes are 18 div, 20 sub, 21 add, 22 sqrt, 24 reciprocal estimate, 25 mul, 26 reciprocal-sqrt estimate, 28 multiply-sub, 29 multiply-add, 30 negative multiply-sub and 31 negative multiply-add. Every other value is illegal.
- R5: In primary opcode 63, `insn[5]`=1 selects the same 5-bit table as R4 plus select at code 23, with `single_prec`=0. `insn[5]`=0 selects the 10-bit table. Its entries are 0 compare-unordered, 12 round-to-single, 14 convert-to-integer, 15 convert-to-integer with truncation, 32 compare-ordered, 38 set status bit, 40 negate, 64 status field to CR, 70 clear status bit, 72 move, 134 status field immediate, 136 negative absolute, 264 absolute, 583 read status and 711 write status under mask. Other values are illegal.
- R6: `src_mask` bit 0, bit 1 and bit 2 mark reads of register A, B and C respectively. Div, sub, add and both compares read A and B. Mul reads A and C. The fused forms and select read A, B and C. Sqrt, both estimates, round, both converts, negate, absolute, negative absolute, move and write-status-under-mask read B. Everything else reads none.
- R7: For immediate-displacement forms, `ea` is the sign-extended `insn[15:0]` plus `base_val`. When `insn[20:16]`=0, zero replaces `base_val`.
- R8: For indexed forms, `ea` is `index_val` plus `base_val`. When `insn[20:16]`=0, zero replaces `base_val`. `ea` is zero for every operation that is not a legal memory operation.
- R9: An update form whose base field `insn[20:16]` is 0 is illegal. A legal update form sets `base_wb`=1. All other operations leave `base_wb` at 0.
- R10: `cr1_copy` equals `insn[0]` for legal non-memory operations and is 0 for memory operations and illegal words.
- R11: The field outputs are taken from the word for every valid word: `rt`=[25:21], `ra`=[20:16], `rb`=[15:11], `rc`=[10:6], `crf`=[25:23], `crf_src`=[20:18], `imm4`=[15:12], `fmask`=[24:17] and `bit_idx`=[25:21].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| base_val | input | AW | Value of the general register named by insn[20:16] |
| index_val | input | AW | Value of the general register named by insn[15:11] |
| out_valid | output | 1 | Decode bundle is new this cycle |
| op | output | 6 | Operation code (fpdec_pkg::fp_op_e) |
| illegal | output | 1 | Word is not a legal floating-point instruction |
| single_prec | output | 1 | Single-precision arithmetic |
| src_mask | output | 3 | Source registers read {C,B,A} |
| is_mem | output | 1 | Legal load or store |
| base_wb | output | 1 | Write ea back to the base register |
| cr1_copy | output | 1 | Copy top status bits to CR field 1 |
| rt | output | 5 | Target register index |
| ra | output | 5 | Register A / base index |
| rb | output | 5 | Register B / index register |
| rc | output | 5 | Register C index |
| crf | output | 3 | Destination CR or status field |
| crf_src | output | 3 | Source status field |
| imm4 | output | 4 | Status field immediate |
| fmask | output | 8 | Status field write mask |
| bit_idx | output | 5 | Status bit index |
| ea | output | AW | Effective address |

## Verification
Every listed extended opcode in each of the three tables is applied directly. The 5-bit codes are sent under both primary 59 and primary 63, which shows that select is accepted only under 63 and that the precision flag follows the primary. Update and plain memory forms are applied with a zero and a non-zero base field, and with negative and positive displacements. This separates the "zero replaces base" rule from the update-form rejection and exposes sign-extension faults. A long random phase mixes listed and unlisted extended values, bit 5 and bit 0 settings and idle gaps, which tests the table boundaries and the hold-while-idle behaviour.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

    typedef enum logic [5:0] {
        OP_ILLEGAL = 6'd0,
        OP_LOAD_S, OP_LOAD_D, OP_STORE_S, OP_STORE_D, OP_STORE_IW,
        OP_DIV, OP_SUB, OP_ADD, OP_SQRT, OP_RECIP_EST, OP_MUL, OP_RSQRT_EST,
        OP_FMSUB, OP_FMADD, OP_FNMSUB, OP_FNMADD, OP_SEL,
        OP_CMP_U, OP_CMP_O, OP_ROUND_S, OP_CVT_INT, OP_CVT_INT_TRUNC,
        OP_SET_BIT, OP_CLR_BIT, OP_NEG, OP_NABS, OP_ABS, OP_MOVE,
        OP_STAT_TO_CR, OP_STAT_FIELD_IMM, OP_READ_STAT, OP_WRITE_STAT_MASK
    } fp_op_e;

    localparam logic [2:0] SRC_A = 3'b001;
    localparam logic [2:0] SRC_B = 3'b010;
    localparam logic [2:0] SRC_C = 3'b100;

    typedef struct packed {
        logic       vld;
        fp_op_e     op;
        logic       illegal;
        logic       sp;
        logic [2:0] src;
        logic       mem;
        logic       wb;
        logic       cr1;
        logic [4:0] rt;
        logic [4:0] ra;
        logic [4:0] rb;
        logic [4:0] rc;
        logic [2:0] crf;
        logic [2:0] crf_src;
        logic [3:0] imm4;
        logic [7:0] fmask;
        logic [4:0] bit_idx;
    } dec_bundle_t;

endpackage

// File: rtl/fpdec_opdecode.sv
module fpdec_opdecode
    import fpdec_pkg::*;
(
    input  logic [31:0] insn,
    output fp_op_e      op,
    output logic        ok,
    output logic        sp,
    output logic [2:0]  src,
    output logic        mem,
    output logic        upd,
    output logic        indexed
);
    logic [5:0] prim;
    logic [9:0] xo10;
    logic [4:0] xo5;
    logic       use5;

    assign prim = insn[31:26];
    assign xo10 = insn[10:1];
    assign xo5  = insn[5:1];
    assign use5 = (prim == 6'd59) || (prim == 6'd63 && insn[5]);

    always_comb begin
        op      = OP_ILLEGAL;
        ok      = 1'b0;
        sp      = 1'b0;
        src     = 3'b000;
        mem     = 1'b0;
        upd     = 1'b0;
        indexed = 1'b0;
        if (use5) begin
            ok = 1'b1;
            sp = (prim == 6'd59);
            case (xo5)
                5'd18: begin op = OP_DIV;       src = SRC_A | SRC_B; end
                5'd20: begin op = OP_SUB;       src = SRC_A | SRC_B; end
                5'd21: begin op = OP_ADD;       src = SRC_A | SRC_B; end
                5'd22: begin op = OP_SQRT;      src = SRC_B; end
                5'd24: begin op = OP_RECIP_EST; src = SRC_B; end
                5'd25: begin op = OP_MUL;       src = SRC_A | SRC_C; end
                5'd26: begin op = OP_RSQRT_EST; src = SRC_B; end
                5'd28: begin op = OP_FMSUB;     src = SRC_A | SRC_B | SRC_C; end
                5'd29: begin op = OP_FMADD;     src = SRC_A | SRC_B | SRC_C; end
                5'd30: begin op = OP_FNMSUB;    src = SRC_A | SRC_B | SRC_C; end
                5'd31: begin op = OP_FNMADD;    src = SRC_A | SRC_B | SRC_C; end
                5'd23: begin
                    if (prim == 6'd63) begin
                        op  = OP_SEL;
                        src = SRC_A | SRC_B | SRC_C;
                    end else begin
                        ok = 1'b0;
                    end
                end
                default: ok = 1'b0;
            endcase
        end else if (prim >= 6'd48 && prim <= 6'd55) begin
            ok  = 1'b1;
            mem = 1'b1;
            upd = prim[0];
            case (prim[2:1])
                2'd0: op = OP_LOAD_S;
                2'd1: op = OP_LOAD_D;
                2'd2: op = OP_STORE_S;
                default: op = OP_STORE_D;
            endcase
        end else if (prim == 6'd31) begin
            ok      = 1'b1;
            mem     = 1'b1;
            indexed = 1'b1;
            case (xo10)
                10'd535: op = OP_LOAD_S;
                10'd567: begin op = OP_LOAD_S;  upd = 1'b1; end
                10'd599: op = OP_LOAD_D;
                10'd631: begin op = OP_LOAD_D;  upd = 1'b1; end
                10'd663: op = OP_STORE_S;
                10'd695: begin op = OP_STORE_S; upd = 1'b1; end
                10'd727: op = OP_STORE_D;
                10'd759: begin op = OP_STORE_D; upd = 1'b1; end
                10'd983: op = OP_STORE_IW;
                default: begin ok = 1'b0; mem = 1'b0; indexed = 1'b0; end
            endcase
        end else if (prim == 6'd63) begin
            ok = 1'b1;
            case (xo10)
                10'd0:   begin op = OP_CMP_U;           src = SRC_A | SRC_B; end
                10'd12:  begin op = OP_ROUND_S;         src = SRC_B; end
                10'd14:  begin op = OP_CVT_INT;         src = SRC_B; end
                10'd15:  begin op = OP_CVT_INT_TRUNC;   src = SRC_B; end
                10'd32:  begin op = OP_CMP_O;           src = SRC_A | SRC_B; end
                10'd38:  op = OP_SET_BIT;
                10'd40:  begin op = OP_NEG;             src = SRC_B; end
                10'd64:  op = OP_STAT_TO_CR;
                10'd70:  op = OP_CLR_BIT;
                10'd72:  begin op = OP_MOVE;            src = SRC_B; end
                10'd134: op = OP_STAT_FIELD_IMM;
                10'd136: begin op = OP_NABS;            src = SRC_B; end
                10'd264: begin op = OP_ABS;             src = SRC_B; end
                10'd583: op = OP_READ_STAT;
                10'd711: begin op = OP_WRITE_STAT_MASK; src = SRC_B; end
                default: ok = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/fpdec_agen.sv
module fpdec_agen #(
    parameter int AW = 32
) (
    input  logic [31:0]   insn,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic          indexed,
    output logic [AW-1:0] ea
);
    localparam int EXT_W = AW - 16;

    logic [AW-1:0] base_eff;
    logic [AW-1:0] disp_ext;
    logic [AW-1:0] offset;

    assign base_eff = (insn[20:16] == 5'd0) ? '0 : base_val;
    assign disp_ext = {{EXT_W{insn[15]}}, insn[15:0]};
    assign offset   = indexed ? index_val : disp_ext;
    assign ea       = base_eff + offset;

endmodule

// File: rtl/fp_insn_decoder.sv
module fp_insn_decoder
    import fpdec_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   insn,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    output logic          out_valid,
    output logic [5:0]    op,
    output logic          illegal,
    output logic          single_prec,
    output logic [2:0]    src_mask,
    output logic          is_mem,
    output logic          base_wb,
    output logic          cr1_copy,
    output logic [4:0]    rt,
    output logic [4:0]    ra,
    output logic [4:0]    rb,
    output logic [4:0]    rc,
    output logic [2:0]    crf,
    output logic [2:0]    crf_src,
    output logic [3:0]    imm4,
    output logic [7:0]    fmask,
    output logic [4:0]    bit_idx,
    output logic [AW-1:0] ea
);
    fp_op_e        dec_op;
    logic          dec_ok, dec_sp, dec_mem, dec_upd, dec_idx;
    logic [2:0]    dec_src;
    logic [AW-1:0] agen_ea;
    logic          bad;

    dec_bundle_t   bun_d, bun_q;
    logic [AW-1:0] ea_d, ea_q;

    fpdec_opdecode u_opdec (
        .insn    (insn),
        .op      (dec_op),
        .ok      (dec_ok),
        .sp      (dec_sp),
        .src     (dec_src),
        .mem     (dec_mem),
        .upd     (dec_upd),
        .indexed (dec_idx)
    );

    fpdec_agen #(.AW(AW)) u_agen (
        .insn      (insn),
        .base_val  (base_val),
        .index_val (index_val),
        .indexed   (dec_idx),
        .ea        (agen_ea)
    );

    assign bad = !dec_ok || (dec_upd && insn[20:16] == 5'd0);

    always_comb begin
        bun_d     = bun_q;
        ea_d      = ea_q;
        bun_d.vld = in_valid;
        if (in_valid) begin
            bun_d.illegal = bad;
            bun_d.op      = bad ? OP_ILLEGAL : dec_op;
            bun_d.sp      = !bad && dec_sp;
            bun_d.src     = bad ? 3'b000 : dec_src;
            bun_d.mem     = !bad && dec_mem;
            bun_d.wb      = !bad && dec_upd;
            bun_d.cr1     = !bad && !dec_mem && insn[0];
            bun_d.rt      = insn[25:21];
            bun_d.ra      = insn[20:16];
            bun_d.rb      = insn[15:11];
            bun_d.rc      = insn[10:6];
            bun_d.crf     = insn[25:23];
            bun_d.crf_src = insn[20:18];
            bun_d.imm4    = insn[15:12];
            bun_d.fmask   = insn[24:17];
            bun_d.bit_idx = insn[25:21];
            ea_d          = (!bad && dec_mem) ? agen_ea : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bun_q <= '0;
            ea_q  <= '0;
        end else begin
            bun_q <= bun_d;
            ea_q  <= ea_d;
        end
    end

    assign out_valid   = bun_q.vld;
    assign op          = bun_q.op;
    assign illegal     = bun_q.illegal;
    assign single_prec = bun_q.sp;
    assign src_mask    = bun_q.src;
    assign is_mem      = bun_q.mem;
    assign base_wb     = bun_q.wb;
    assign cr1_copy    = bun_q.cr1;
    assign rt          = bun_q.rt;
    assign ra          = bun_q.ra;
    assign rb          = bun_q.rb;
    assign rc          = bun_q.rc;
    assign crf         = bun_q.crf;
    assign crf_src     = bun_q.crf_src;
    assign imm4        = bun_q.imm4;
    assign fmask       = bun_q.fmask;
    assign bit_idx     = bun_q.bit_idx;
    assign ea          = ea_q;

endmodule

// File: rtl/fpdec_chk.sv
module fpdec_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [5:0]    op,
    input logic          illegal,
    input logic          is_mem,
    input logic          base_wb,
    input logic          cr1_copy,
    input logic [4:0]    ra,
    input logic [AW-1:0] ea
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(op) && $stable(ea) && $stable(illegal)));

    // R3
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (op == 6'd0 && !is_mem && !base_wb && !cr1_copy));

    // R9
    wb_base_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wb |-> (ra != 5'd0 && is_mem));

    // R8
    ea_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mem |-> (ea == '0));

    // R10
    cr1_not_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr1_copy |-> !is_mem);

endmodule

bind fp_insn_decoder fpdec_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .op        (op),
    .illegal   (illegal),
    .is_mem    (is_mem),
    .base_wb   (base_wb),
    .cr1_copy  (cr1_copy),
    .ra        (ra),
    .ea        (ea)
);

// File: tb/fp_insn_decoder_tb.sv
module fp_insn_decoder_tb;
    import fpdec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;

    logic        out_valid, illegal, single_prec, is_mem, base_wb, cr1_copy;
    logic [5:0]  op;
    logic [2:0]  src_mask, crf, crf_src;
    logic [4:0]  rt, ra, rb, rc, bit_idx;
    logic [3:0]  imm4;
    logic [7:0]  fmask;
    logic [31:0] ea;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fp_insn_decoder #(.AW(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .base_val(base_val), .index_val(index_val),
        .out_valid(out_valid), .op(op), .illegal(illegal),
        .single_prec(single_prec), .src_mask(src_mask), .is_mem(is_mem),
        .base_wb(base_wb), .cr1_copy(cr1_copy), .rt(rt), .ra(ra), .rb(rb),
        .rc(rc), .crf(crf), .crf_src(crf_src), .imm4(imm4), .fmask(fmask),
        .bit_idx(bit_idx), .ea(ea)
    );

    // expected state (reference model output)
    logic        e_vld = 0, e_ill = 0, e_sp = 0, e_mem = 0, e_wb = 0, e_cr1 = 0;
    logic [5:0]  e_op = 0;
    logic [2:0]  e_src = 0;
    logic [31:0] e_word = 0;
    logic [31:0] e_ea = 0;
    string       e_tag = "R1";
    string       e_eatag = "R1";

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1", "out_valid", out_valid, e_vld);
        chk(e_tag, "op", op, e_op);
        chk(e_tag, "illegal", illegal, e_ill);
        chk(e_tag, "single_prec", single_prec, e_sp);
        chk("R6", "src_mask", src_mask, e_src);
        chk(e_tag, "is_mem", is_mem, e_mem);
        chk("R9", "base_wb", base_wb, e_wb);
        chk("R10", "cr1_copy", cr1_copy, e_cr1);
        chk(e_eatag, "ea", ea, e_ea);
        chk("R11", "rt/ra/rb/rc", {rt, ra, rb, rc},
            {e_word[25:21], e_word[20:16], e_word[15:11], e_word[10:6]});
        chk("R11", "crf/crf_src/imm4", {crf, crf_src, imm4},
            {e_word[25:23], e_word[20:18], e_word[15:12]});
        chk("R11", "fmask/bit_idx", {fmask, bit_idx}, {e_word[24:17], e_word[25:21]});
    endtask

    // behavioural reference: classify with integers
    task automatic model(input logic [31:0] w, input logic [31:0] b,
                         input logic [31:0] x, input bit v);
        int p, x10, x5;
        bit ok, upd, ixd, mem, sp;
        fp_op_e o;
        logic [2:0] s;
        logic [31:0] bb;
        e_vld = v;
        if (!v) return;
        p = int'(w[31:26]); x10 = int'(w[10:1]); x5 = int'(w[5:1]);
        ok = 0; upd = 0; ixd = 0; mem = 0; sp = 0; o = OP_ILLEGAL; s = 0;
        e_tag = "R3"; e_eatag = "R8";
        if (p == 59 || (p == 63 && w[5])) begin
            e_tag = (p == 59) ? "R4" : "R5";
            sp = (p == 59); ok = 1;
            case (x5)
                18: begin o = OP_DIV; s = 3; end
                20: begin o = OP_SUB; s = 3; end
                21: begin o = OP_ADD; s = 3; end
                22: begin o = OP_SQRT; s = 2; end
                23: begin o = OP_SEL; s = 7; ok = (p == 63); end
                24: begin o = OP_RECIP_EST; s = 2; end
                25: begin o = OP_MUL; s = 5; end
                26: begin o = OP_RSQRT_EST; s = 2; end
                28: begin o = OP_FMSUB; s = 7; end
                29: begin o = OP_FMADD; s = 7; end
                30: begin o = OP_FNMSUB; s = 7; end
                31: begin o = OP_FNMADD; s = 7; end
                default: ok = 0;
            endcase
        end else if (p >= 48 && p <= 55) begin
            e_tag = "R2"; e_eatag = "R7";
            ok = 1; mem = 1; upd = (p % 2) == 1;
            case ((p - 48) / 2)
                0: o = OP_LOAD_S;
                1: o = OP_LOAD_D;
                2: o = OP_STORE_S;
                default: o = OP_STORE_D;
            endcase
        end else if (p == 31) begin
            ok = 1; mem = 1; ixd = 1;
            case (x10)
                535: o = OP_LOAD_S;
                567: begin o = OP_LOAD_S; upd = 1; end
                599: o = OP_LOAD_D;
                631: begin o = OP_LOAD_D; upd = 1; end
                663: o = OP_STORE_S;
                695: begin o = OP_STORE_S; upd = 1; end
                727: o = OP_STORE_D;
                759: begin o = OP_STORE_D; upd = 1; end
                983: o = OP_STORE_IW;
                default: ok = 0;
            endcase
        end else if (p == 63) begin
            e_tag = "R5"; ok = 1;
            case (x10)
                0:   begin o = OP_CMP_U; s = 3; end
                12:  begin o = OP_ROUND_S; s = 2; end
                14:  begin o = OP_CVT_INT; s = 2; end
                15:  begin o = OP_CVT_INT_TRUNC; s = 2; end
                32:  begin o = OP_CMP_O; s = 3; end
                38:  o = OP_SET_BIT;
                40:  begin o = OP_NEG; s = 2; end
                64:  o = OP_STAT_TO_CR;
                70:  o = OP_CLR_BIT;
                72:  begin o = OP_MOVE; s = 2; end
                134: o = OP_STAT_FIELD_IMM;
                136: begin o = OP_NABS; s = 2; end
                264: begin o = OP_ABS; s = 2; end
                583: o = OP_READ_STAT;
                711: begin o = OP_WRITE_STAT_MASK; s = 2; end
                default: ok = 0;
            endcase
        end
        if (upd && w[20:16] == 0) begin ok = 0; e_tag = "R9"; end
        e_word = w;
        e_ill  = !ok;
        e_op   = ok ? o : OP_ILLEGAL;
        e_sp   = ok && sp;
        e_src  = ok ? s : 3'b000;
        e_mem  = ok && mem;
        e_wb   = ok && upd;
        e_cr1  = ok && !mem && w[0];
        bb     = (w[20:16] == 0) ? 32'd0 : b;
        if (ok && mem)
            e_ea = ixd ? bb + x : bb + {{16{w[15]}}, w[15:0]};
        else
            e_ea = 0;
    endtask

    // one cycle: check previous result, then present new input
    task automatic step(input logic [31:0] w, input logic [31:0] b,
                        input logic [31:0] x, input bit v);
        @(negedge clk);
        compare_all();
        in_valid = v; insn = w; base_val = b; index_val = x;
        model(w, b, x, v);
    endtask

    function automatic logic [31:0] mk_d(int p, int t, int a, int d);
        return {6'(p), 5'(t), 5'(a), 16'(d)};
    endfunction
    function automatic logic [31:0] mk_x(int p, int t, int a, int b, int xo, bit rcb);
        return {6'(p), 5'(t), 5'(a), 5'(b), 10'(xo), rcb};
    endfunction
    function automatic logic [31:0] mk_a(int p, int t, int a, int b, int c, int xo, bit rcb);
        return {6'(p), 5'(t), 5'(a), 5'(b), 5'(c), 5'(xo), rcb};
    endfunction

    int x31_list[9] = '{535, 567, 599, 631, 663, 695, 727, 759, 983};
    int x63_list[15] = '{0, 12, 14, 15, 32, 38, 40, 64, 70, 72, 134, 136, 264, 583, 711};

    initial begin
        // reset state (R1): expected all zero
        repeat (3) @(negedge clk);
        compare_all();
        rst_n = 1'b1;

        // R2 immediate forms, positive/negative displacement, base 0
        step(mk_d(48, 1, 3, -4), 32'h1000, 0, 1);
        step(mk_d(49, 2, 5, 16), 32'h2000, 0, 1);
        step(mk_d(49, 2, 0, 16), 32'h2000, 0, 1);        // R9 update, base 0
        step(mk_d(54, 7, 0, 32'h8000), 32'h3000, 0, 1);  // R7 zero base, neg disp
        step(mk_d(51, 9, 31, 32'h7fff), 32'hffff_fff0, 0, 1);
        step(mk_d(55, 9, 4, -1), 32'h10, 0, 1);
        // idle holds (R1)
        step(0, 32'hdead, 32'hbeef, 0);
        step(mk_d(48, 1, 1, 1), 32'h55, 0, 0);
        // R3 indexed
        foreach (x31_list[i]) begin
            step(mk_x(31, 3, i % 3, 6, x31_list[i], 1), 32'h400 + i, 32'h20 * i, 1);
        end
        step(mk_x(31, 3, 4, 6, 536, 0), 32'h1, 32'h2, 1);
        step(mk_x(31, 3, 4, 6, 0, 0), 32'h1, 32'h2, 1);
        step(mk_d(0, 0, 0, 0), 0, 0, 1);
        step(mk_d(60, 1, 2, 3), 0, 0, 1);
        // R4 / R5 5-bit tables under both primaries, bit0 alternating (R10)
        for (int c = 0; c < 32; c++) begin
            step(mk_a(59, 1, 2, 3, 4, c, c[0]), 0, 0, 1);
            step(mk_a(63, 5, 6, 7, 8, c, !c[0]), 0, 0, 1);
        end
        // R5 10-bit table
        foreach (x63_list[i]) begin
            step(mk_x(63, 29 - i, i, 31 - i, x63_list[i], i[0]), 0, 0, 1);
        end
        step(mk_x(63, 1, 1, 1, 2, 1), 0, 0, 1);
        step(mk_x(63, 1, 1, 1, 710, 1), 0, 0, 1);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] w;
            int sel;
            w = $urandom;
            sel = $urandom % 6;
            case (sel)
                0: w[31:26] = 6'd31;
                1: w[31:26] = 6'(48 + $urandom % 8);
                2: w[31:26] = 6'd59;
                3: w[31:26] = 6'd63;
                default: ;
            endcase
            if (sel == 0 && $urandom % 2 == 1) w[10:1] = 10'(x31_list[$urandom % 9]);
            if (sel == 3 && $urandom % 2 == 1) w[10:1] = 10'(x63_list[$urandom % 15]);
            step(w, $urandom, $urandom, ($urandom % 4) != 0);
        end
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule